// File: doc/BRIEF.md
# Single-Wire Half-Duplex Serial Port

This block carries byte traffic to and from a host computer over one shared pin. Transmit and receive use the same wire. The pin is wired-OR with an external pullup, so the block never drives it high. It only enables a low-side driver (`pad_pull_low`) and reads the resulting level back (`pad_in`). Bytes use plain mark/space non-return-to-zero framing. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit, with no parity. Every bit lasts `baud_div` clock cycles. With the block clock fixed, this divisor sets the bit rate, and the intended range is 4800 baud to 28.8 kbaud.

The transmit side takes bytes through a valid/ready handshake. The receive side delivers each byte with a one-cycle strobe, or raises a framing-error strobe instead. The line input is resynchronised through two flops before any edge detection. Because the block sees its own transmitted bits on the shared wire, the receiver is held idle while a frame is going out. Because the link is half duplex, no transmission starts while a reception is in progress.

The transmitter FSM has four states:
- `TX_IDLE` moves to `TX_START` when a byte is accepted.
- `TX_START` moves to `TX_DATA` after one bit time.
- `TX_DATA` moves to `TX_STOP` after the eighth bit.
- `TX_STOP` moves to `TX_IDLE` after one bit time.

The receiver FSM also has four states:
- `RX_IDLE` moves to `RX_START` on a falling edge while no transmission is in progress.
- `RX_START` moves to `RX_DATA` if the line is still low at half a bit time. Otherwise it returns to `RX_IDLE`, because the low was a glitch.
- `RX_DATA` samples one bit per bit time and moves to `RX_STOP` after the eighth.
- `RX_STOP` samples the stop bit one bit time later, strobes data or an error, and returns to `RX_IDLE`.

Top module: `sw_serial_port`

## Requirements
- R1: After reset, `pad_pull_low` is 0, `tx_ready` is 1, and `rx_valid` and `rx_frame_err` are 0.
- R2: A transmitted frame holds the line low for one start bit, then puts out the 8 data bits least significant bit first, then releases it for one high stop bit. `pad_pull_low` is 1 exactly for low bits and 0 whenever the transmitter is idle.
- R3: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from that edge until the stop bit has ended.
- R4: A received frame with a high stop bit produces a single one-cycle `rx_valid` pulse, with `rx_data` holding the byte assembled least significant bit first.
- R5: A received frame whose stop bit samples low produces a one-cycle `rx_frame_err` pulse and no `rx_valid`.
- R6: A low pulse on an idle line that ends before half a bit time produces neither `rx_valid` nor `rx_frame_err`.
- R7: While the block is transmitting, its own bits on the line produce neither `rx_valid` nor `rx_frame_err`.
- R8: While a frame is being received, `tx_ready` is 0.
- R9: Each bit lasts exactly `baud_div` clock cycles, for any `baud_div` of at least 4, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Clock cycles per bit, at least 4 |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DATA_W | Byte to transmit |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a good byte |
| rx_data | output | DATA_W | Last received byte |
| rx_frame_err | output | 1 | One-cycle strobe: stop bit sampled low |
| pad_pull_low | output | 1 | Enable for the open-drain low driver |
| pad_in | input | 1 | Level read back from the shared pin |

## Verification
The bench models the wired-OR pin: the line is low when either the block or the host model pulls it. This lets the block's own echo reach its receiver exactly as it would on the board.

It sends the bytes 0x00, 0xFF and single-bit patterns. A design that shifted data the wrong way, or miscounted the bit index, would return mirrored or shifted bytes. It also sends a frame with a low stop bit. A design without the stop check would deliver that byte as good data.

It drives a two-cycle glitch. A design without the mid-start check would assemble a phantom byte. It transmits and watches the receive strobes. A receiver that is not gated would report its own echo as incoming data.

It runs at two divisors and checks `tx_ready` during a reception. Bit times that ignore `baud_div` would fail those checks, and so would a transmitter that collides with an incoming frame.

// File: rtl/swsp_pkg.sv
package swsp_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/swsp_sync.sv
module swsp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/swsp_tx.sv
module swsp_tx
    import swsp_pkg::*;
#(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              pull_low
);
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         state_q, state_d;
    logic [DIV_W-1:0]  cnt_q, cnt_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic              bit_end;

    assign bit_end = (cnt_q == baud_div - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = bit_end ? '0 : cnt_q + DIV_W'(1);
        bit_d   = bit_q;
        sh_d    = sh_q;
        unique case (state_q)
            TX_IDLE: begin
                cnt_d = '0;
                if (start) begin
                    state_d = TX_START;
                    sh_d    = data;
                    bit_d   = '0;
                end
            end
            TX_START: begin
                if (bit_end) state_d = TX_DATA;
            end
            TX_DATA: begin
                if (bit_end) begin
                    sh_d = sh_q >> 1;
                    if (bit_q == BIT_W'(DATA_W - 1)) state_d = TX_STOP;
                    else                             bit_d   = bit_q + BIT_W'(1);
                end
            end
            TX_STOP: begin
                if (bit_end) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q != TX_IDLE);
        pull_low = 1'b0;
        unique case (state_q)
            TX_IDLE:  pull_low = 1'b0;
            TX_START: pull_low = 1'b1;
            TX_DATA:  pull_low = ~sh_q[0];
            TX_STOP:  pull_low = 1'b0;
            default:  pull_low = 1'b0;
        endcase
    end

    // R2: the stop bit is always released to the pullup
    a_r2_stop_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_STOP) |-> !pull_low);

    // R2: the start bit always pulls low
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_START) |-> pull_low);
endmodule

// File: rtl/swsp_rx.sv
module swsp_rx
    import swsp_pkg::*;
#(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              line,
    input  logic              mute,
    output logic              idle,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              frame_err
);
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         state_q, state_d;
    logic [DIV_W-1:0]  cnt_q, cnt_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic              valid_q, valid_d;
    logic              ferr_q, ferr_d;
    logic              prev_q;
    logic              bit_end, half_end, fall;

    assign bit_end  = (cnt_q == baud_div - DIV_W'(1));
    assign half_end = (cnt_q == (baud_div >> 1) - DIV_W'(1));
    assign fall     = prev_q & ~line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
            prev_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
            data_q  <= data_d;
            valid_q <= valid_d;
            ferr_q  <= ferr_d;
            prev_q  <= line;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = bit_end ? '0 : cnt_q + DIV_W'(1);
        bit_d   = bit_q;
        sh_d    = sh_q;
        data_d  = data_q;
        valid_d = 1'b0;
        ferr_d  = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                cnt_d = '0;
                if (fall && !mute) state_d = RX_START;
            end
            RX_START: begin
                cnt_d = cnt_q + DIV_W'(1);
                if (half_end) begin
                    cnt_d = '0;
                    bit_d = '0;
                    state_d = line ? RX_IDLE : RX_DATA;
                end
            end
            RX_DATA: begin
                if (bit_end) begin
                    sh_d = {line, sh_q[DATA_W-1:1]};
                    if (bit_q == BIT_W'(DATA_W - 1)) state_d = RX_STOP;
                    else                             bit_d   = bit_q + BIT_W'(1);
                end
            end
            RX_STOP: begin
                if (bit_end) begin
                    state_d = RX_IDLE;
                    if (line) begin
                        valid_d = 1'b1;
                        data_d  = sh_q;
                    end else begin
                        ferr_d  = 1'b1;
                    end
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_comb begin
        idle      = (state_q == RX_IDLE);
        valid     = valid_q;
        frame_err = ferr_q;
        data      = data_q;
    end

    // R5: a frame is either good or bad, never both
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && frame_err));

    // R4: the valid strobe lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/sw_serial_port.sv
module sw_serial_port
    import swsp_pkg::*;
#(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_frame_err,
    output logic              pad_pull_low,
    input  logic              pad_in
);
    logic line_sync;
    logic tx_busy;
    logic rx_idle;
    logic tx_go;

    swsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (line_sync)
    );

    assign tx_ready = !tx_busy && rx_idle;
    assign tx_go    = tx_valid && tx_ready;

    swsp_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .baud_div (baud_div),
        .start    (tx_go),
        .data     (tx_data),
        .busy     (tx_busy),
        .pull_low (pad_pull_low)
    );

    swsp_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_div  (baud_div),
        .line      (line_sync),
        .mute      (tx_busy),
        .idle      (rx_idle),
        .valid     (rx_valid),
        .data      (rx_data),
        .frame_err (rx_frame_err)
    );

    // R3: acceptance drops ready on the following cycle
    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R7: no receive strobe while the transmitter owns the line
    a_r7_no_echo: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !(rx_valid || rx_frame_err));

    // R2: the driver is released whenever the transmitter is idle
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !pad_pull_low);
endmodule

// File: tb/sw_serial_port_tb.sv
module sw_serial_port_tb;
    localparam int DIV_W  = 16;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [7:0]  data;
        logic        stop_ok;
        logic [15:0] div;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 1'b1, 16'd8},
        '{8'h00, 1'b1, 16'd8},
        '{8'hFF, 1'b1, 16'd8},
        '{8'h01, 1'b1, 16'd12},
        '{8'h80, 1'b1, 16'd12},
        '{8'h3C, 1'b0, 16'd8},
        '{8'h5A, 1'b1, 16'd9}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  baud_div = 16'd8;
    logic              tx_valid = 1'b0;
    logic [DATA_W-1:0] tx_data = '0;
    logic              tx_ready, rx_valid, rx_frame_err, pad_pull_low;
    logic [DATA_W-1:0] rx_data;
    logic              host_low = 1'b0;
    logic              pad_in;

    int n_run = 0;
    int n_fail = 0;
    int n_valid = 0;
    int n_ferr = 0;
    logic [7:0] got_data = '0;

    assign pad_in = !(pad_pull_low || host_low);

    always #5 clk = ~clk;

    sw_serial_port #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_div     (baud_div),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_ready     (tx_ready),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_frame_err (rx_frame_err),
        .pad_pull_low (pad_pull_low),
        .pad_in       (pad_in)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            n_valid  = n_valid + 1;
            got_data = rx_data;
        end
        if (rx_frame_err) n_ferr = n_ferr + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic host_send(input logic [7:0] b, input logic stop_ok);
        int d;
        d = int'(baud_div);
        @(negedge clk);
        host_low = 1'b1;
        repeat (d) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            host_low = ~b[i];
            repeat (d) @(negedge clk);
            if (i == 3) check("R8 tx_ready during rx", int'(tx_ready), 0);
        end
        host_low = ~stop_ok;
        repeat (d) @(negedge clk);
        host_low = 1'b0;
        repeat (d + 4) @(negedge clk);
    endtask

    task automatic dut_send(input logic [7:0] b, input string req);
        int d;
        logic [9:0] frame;
        d = int'(baud_div);
        frame = {1'b1, b, 1'b0};
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = b;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        check("R3 ready low after accept", int'(tx_ready), 0);
        repeat (d / 2) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            check(req, int'(pad_in), int'(frame[i]));
            if (i < 9) repeat (d) @(negedge clk);
        end
        check("R3 ready low in stop", int'(tx_ready), 0);
        repeat (d - d / 2 + 1) @(negedge clk);
        check("R3 ready back after stop", int'(tx_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pad released", int'(pad_pull_low), 0);
        check("R1 tx_ready", int'(tx_ready), 1);
        check("R1 rx_valid", int'(rx_valid), 0);
        check("R1 rx_frame_err", int'(rx_frame_err), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 R5 R9: table-driven host frames
        for (int v = 0; v < NV; v++) begin
            baud_div = VECS[v].div;
            n_valid = 0;
            n_ferr  = 0;
            host_send(VECS[v].data, VECS[v].stop_ok);
            if (VECS[v].stop_ok) begin
                check("R4 valid count", n_valid, 1);
                check("R4 R9 rx byte", int'(got_data), int'(VECS[v].data));
                check("R5 no ferr on good frame", n_ferr, 0);
            end else begin
                check("R5 ferr count", n_ferr, 1);
                check("R5 no valid on bad frame", n_valid, 0);
            end
        end

        // R6: two-cycle glitch on idle line
        baud_div = 16'd8;
        n_valid = 0;
        n_ferr  = 0;
        @(negedge clk);
        host_low = 1'b1;
        repeat (2) @(negedge clk);
        host_low = 1'b0;
        repeat (100) @(negedge clk);
        check("R6 glitch valid", n_valid, 0);
        check("R6 glitch ferr", n_ferr, 0);
        check("R6 ready after glitch", int'(tx_ready), 1);

        // R2 R7 R9: transmit at two divisors, echo must be ignored
        n_valid = 0;
        n_ferr  = 0;
        dut_send(8'hB4, "R2 tx frame div8");
        baud_div = 16'd12;
        dut_send(8'h3B, "R9 tx frame div12");
        repeat (30) @(negedge clk);
        check("R7 echo valid", n_valid, 0);
        check("R7 echo ferr", n_ferr, 0);

        // R4: receive still works after transmitting
        host_send(8'hC3, 1'b1);
        check("R4 rx after tx", int'(got_data), 8'hC3);
        check("R4 count after tx", n_valid, 1);

        finish_run();
    end
endmodule